// File: doc/BRIEF.md
# Multi-Cycle Load Sequencer

This block runs one load instruction at a time through six fixed register-transfer steps. A program counter, a memory address register, a memory data register, an instruction register and a 32-entry register file sit behind a single synchronous read port. Every step performs one group of transfers. The instruction word is fetched through the address and data registers, and the program counter advances by four during that fetch. The word is then decoded, and the operand is read at a base register plus a signed offset. Finally the operand is written into the destination register.

A pulse on `start` while the sequencer is idle begins an instruction. `done` marks the final step, and the block then waits for the next `start`. The memory has a latency of one cycle: the word for the address presented while `mem_rd` is high arrives on `mem_rdata` in the following cycle. The program counter and the instruction register are visible on debug outputs. Only the load opcode is executed. Any other opcode raises `illegal` and returns the block to idle.

Top module: `load_seq_core`

## Requirements
- R1: After a synchronous active-low reset, the program counter, the instruction register and every register-file entry are zero, and `done`, `illegal` and `mem_rd` are low.
- R2: In the first cycle after `start` is accepted, `mem_rd` is high and `mem_addr` equals the program counter. From the next cycle on, `dbg_pc` reads the old value plus 4.
- R3: The fetched word, returned one cycle after the read strobe, is held in the instruction register and shown on `dbg_ir` from the fourth cycle after `start` is accepted.
- R4: The instruction format is as follows. Bits [31:26] hold the opcode, with 6'h23 meaning load. Bits [25:21] select the base register, bits [20:16] select the destination register, and bits [15:0] hold a two's-complement offset.
- R5: For a load, `mem_rd` is high again in the fourth cycle with `mem_addr` equal to the base register plus the sign-extended offset. Negative offsets subtract.
- R6: The operand word returned for that read is written into the destination register. A later load that uses this register as its base observes the new value.
- R7: `done` is high for exactly one cycle, the sixth after `start` is accepted. The block then idles until the next `start`.
- R8: Register 0 always reads as zero. A load that targets it has no effect on later address calculations.
- R9: If the opcode is not 6'h23, `illegal` is high for one cycle, the third after `start`. No operand read follows, `done` stays low, the program counter keeps its advanced value, and the block returns to idle.
- R10: `start` is ignored while an instruction is in progress, so no second fetch begins before the current instruction ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin one instruction when idle |
| mem_addr | output | 32 | Read address |
| mem_rd | output | 1 | Read strobe; data returns next cycle |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle pulse for an unsupported opcode |
| dbg_pc | output | 32 | Current program counter |
| dbg_ir | output | 32 | Current instruction register |

## Verification
The tests run a chain of loads in which each one takes its base from a register that an earlier load wrote. The chain uses a zero base, a positive offset, a negative offset and a base written by the previous load. A wrong effective address therefore shows up as an unexpected second read address, and a missing register write does too. A load into register 0 followed by a load based on register 0 shows whether writes to that register are discarded. An illegal opcode, followed by a legal load, shows whether the block drops the operand read, keeps the advanced program counter and recovers. A legal load with `start` held high during its busy steps shows whether extra fetches can be triggered.

// File: rtl/ldseq_pkg.sv
// Shared types and instruction-field helpers for the load sequencer.
// Assumes a 32-bit instruction word with 5-bit register indices.
package ldseq_pkg;
    localparam int INSN_W    = 32;
    localparam int REG_IDX_W = 5;
    localparam int OFF_W     = 16;
    localparam logic [5:0] OP_LOAD = 6'h23;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_MDR_I,
        ST_IR,
        ST_EA,
        ST_MDR_D,
        ST_WB
    } step_t;

    function automatic logic [5:0] f_opcode(input logic [INSN_W-1:0] w);
        return w[31:26];
    endfunction

    function automatic logic [REG_IDX_W-1:0] f_base(input logic [INSN_W-1:0] w);
        return w[25:21];
    endfunction

    function automatic logic [REG_IDX_W-1:0] f_dest(input logic [INSN_W-1:0] w);
        return w[20:16];
    endfunction

    function automatic logic [OFF_W-1:0] f_off(input logic [INSN_W-1:0] w);
        return w[15:0];
    endfunction
endpackage

// File: rtl/ldseq_ctrl.sv
// Step sequencer: walks idle -> fetch -> data capture -> decode -> address
// -> operand capture -> write-back. Assumes op_is_load is valid in ST_IR.
module ldseq_ctrl
    import ldseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    input  logic  op_is_load,
    output step_t step,
    output logic  done,
    output logic  illegal
);
    step_t step_nxt;

    // Next-step selection.
    always_comb begin
        step_nxt = step;
        unique case (step)
            ST_IDLE:  if (start) step_nxt = ST_FETCH;
            ST_FETCH: step_nxt = ST_MDR_I;
            ST_MDR_I: step_nxt = ST_IR;
            ST_IR:    step_nxt = op_is_load ? ST_EA : ST_IDLE;
            ST_EA:    step_nxt = ST_MDR_D;
            ST_MDR_D: step_nxt = ST_WB;
            ST_WB:    step_nxt = ST_IDLE;
            default:  step_nxt = ST_IDLE;
        endcase
    end

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n) step <= ST_IDLE;
        else        step <= step_nxt;
    end

    assign done    = (step == ST_WB);
    assign illegal = (step == ST_IR) && !op_is_load;

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    illegal_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> (step == ST_IDLE));
    // R10
    busy_nostart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step != ST_IDLE) |=> (step != ST_FETCH));
    // R7
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && illegal));
endmodule

// File: rtl/ldseq_regfile.sv
// Register file with one read port and one write port. Entry 0 is held at
// zero and never written. Assumes NREG is a power of two.
module ldseq_regfile #(
    parameter int NREG = 32,
    parameter int XLEN = 32,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] raddr,
    output logic [XLEN-1:0]  rdata,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [XLEN-1:0]  wdata
);
    logic [XLEN-1:0] regs [NREG];

    // Storage update; writes to entry 0 are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata = regs[raddr];

    // R8
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        regs[0] == '0);
endmodule

// File: rtl/load_seq_core.sv
// Multi-cycle load sequencer top. Holds the program counter, the address,
// data and instruction registers, and drives a read port with one cycle of
// latency. Assumes 32-bit instructions in the format described in the brief.
module load_seq_core
    import ldseq_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    parameter int PC_STEP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic [XLEN-1:0] mem_addr,
    output logic            mem_rd,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            done,
    output logic            illegal,
    output logic [XLEN-1:0] dbg_pc,
    output logic [XLEN-1:0] dbg_ir
);
    localparam int IDX_W = $clog2(NREG);

    step_t           step;
    logic [XLEN-1:0] pc, mar, mdr, ir;
    logic [XLEN-1:0] base_val, ea, off_ext;
    logic            op_is_load;

    ldseq_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .op_is_load (op_is_load),
        .step       (step),
        .done       (done),
        .illegal    (illegal)
    );

    ldseq_regfile #(.NREG(NREG), .XLEN(XLEN)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .raddr (IDX_W'(f_base(ir))),
        .rdata (base_val),
        .we    (step == ST_WB),
        .waddr (IDX_W'(f_dest(ir))),
        .wdata (mdr)
    );

    // Decode opcode from the word about to enter the instruction register.
    assign op_is_load = (f_opcode(mdr) == OP_LOAD);

    // Effective address: base plus sign-extended offset.
    assign off_ext = {{(XLEN-OFF_W){ir[OFF_W-1]}}, f_off(ir)};
    assign ea      = base_val + off_ext;

    // Read port: address taken from its source in the strobe step.
    always_comb begin
        unique case (step)
            ST_FETCH: mem_addr = pc;
            ST_EA:    mem_addr = ea;
            default:  mem_addr = mar;
        endcase
    end
    assign mem_rd = (step == ST_FETCH) || (step == ST_EA);

    // Program counter and address register transfers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc  <= '0;
            mar <= '0;
        end else if (step == ST_FETCH) begin
            mar <= pc;
            pc  <= pc + XLEN'(PC_STEP);
        end else if (step == ST_EA) begin
            mar <= ea;
        end
    end

    // Data register captures returned words; instruction register loads from it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdr <= '0;
            ir  <= '0;
        end else begin
            if (step == ST_MDR_I || step == ST_MDR_D) mdr <= mem_rdata;
            if (step == ST_IR) ir <= mdr;
        end
    end

    assign dbg_pc = pc;
    assign dbg_ir = ir;

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step == ST_FETCH) |=> (dbg_pc == $past(dbg_pc) + XLEN'(PC_STEP)));
    // R5
    rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);
    // R3
    ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step != ST_IR) |=> $stable(dbg_ir));
    // R9
    no_operand_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> !mem_rd);
endmodule

// File: tb/test_load_seq_core.sv
module test_load_seq_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] mem_addr, mem_rdata, dbg_pc, dbg_ir;
    logic        mem_rd, done, illegal;
    int          checks = 0;
    int          fails = 0;
    bit          finished = 1'b0;
    logic [31:0] mem [256];

    always #2.5 clk = ~clk;

    load_seq_core i_load_seq_core (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
        .done(done), .illegal(illegal), .dbg_pc(dbg_pc), .dbg_ir(dbg_ir)
    );

    // Memory model: one cycle of read latency.
    always_ff @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[9:2]];
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input logic [5:0] op, input logic [4:0] b,
                                        input logic [4:0] d, input logic [15:0] off);
        return {op, b, d, off};
    endfunction

    // One instruction; cycle n is the n-th negedge after start is accepted.
    task automatic run_insn(input string tag, input logic [31:0] pc0,
                            input logic [31:0] word, input bit exp_ill,
                            input logic [31:0] exp_ea, input bit hold);
        int rd_n = 0, done_n = 0, ill_n = 0;
        int done_cyc = 0, ill_cyc = 0, rd2_cyc = 0;
        logic [31:0] rd1 = '0, rd2 = '0, pc2 = '0, ir4 = '0;
        @(negedge clk) start = 1'b1;
        @(posedge clk);
        for (int n = 1; n <= 10; n++) begin
            @(negedge clk);
            start = hold && (n >= 1) && (n <= 4);
            if (mem_rd) begin
                rd_n++;
                if (rd_n == 1) rd1 = mem_addr;
                if (rd_n == 2) begin rd2 = mem_addr; rd2_cyc = n; end
            end
            if (done) begin done_n++; done_cyc = n; end
            if (illegal) begin ill_n++; ill_cyc = n; end
            if (n == 2) pc2 = dbg_pc;
            if (n == 4) ir4 = dbg_ir;
        end
        start = 1'b0;
        $display("-- %s", tag);
        chk("R2 fetch address", rd1, pc0);
        chk("R2 pc advance", pc2, pc0 + 32'd4);
        chk("R3 ir contents", ir4, word);
        if (exp_ill) begin
            chk("R9 illegal count", ill_n, 1);
            chk("R9 illegal cycle", ill_cyc, 3);
            chk("R9 no operand read", rd_n, 1);
            chk("R9 no done", done_n, 0);
            chk("R9 pc kept", dbg_pc, pc0 + 32'd4);
        end else begin
            chk("R10 read count", rd_n, 2);
            chk("R5 operand address", rd2, exp_ea);
            chk("R5 operand read cycle", rd2_cyc, 4);
            chk("R7 done count", done_n, 1);
            chk("R7 done cycle", done_cyc, 6);
            chk("R9 no illegal", ill_n, 0);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 pc", dbg_pc, 0);
        chk("R1 ir", dbg_ir, 0);
        chk("R1 done", done, 0);
        chk("R1 illegal", illegal, 0);
        chk("R1 mem_rd", mem_rd, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7 idle without start", mem_rd, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 + i;
        // Program (R4 format, opcode 6'h23 = load)
        mem[0] = enc(6'h23, 5'd0, 5'd1, 16'h0080); // r1 <- [0x80]
        mem[1] = enc(6'h23, 5'd1, 5'd2, 16'hFFFC); // r2 <- [r1-4]
        mem[2] = enc(6'h23, 5'd2, 5'd3, 16'h0010); // r3 <- [r2+16]
        mem[3] = enc(6'h23, 5'd1, 5'd0, 16'h0000); // r0 <- [r1]
        mem[4] = enc(6'h23, 5'd0, 5'd4, 16'h0020); // r4 <- [r0+32]
        mem[5] = enc(6'h2B, 5'd1, 5'd5, 16'h0000); // illegal
        mem[6] = enc(6'h23, 5'd3, 5'd5, 16'h0004); // r5 <- [r3+4]
        mem[32]  = 32'h0000_0100;
        mem[63]  = 32'h0000_0200;
        mem[132] = 32'h0000_0054;
        mem[64]  = 32'h0000_0300;
        t_reset();
        run_insn("R1 R5 zero base, positive offset", 32'd0,  mem[0], 0, 32'h80,  0);
        run_insn("R5 negative offset", 32'd4,  mem[1], 0, 32'hFC,  0);
        run_insn("R6 base from previous load", 32'd8,  mem[2], 0, 32'h210, 0);
        run_insn("R8 load into r0", 32'd12, mem[3], 0, 32'h100, 0);
        run_insn("R8 r0 still zero", 32'd16, mem[4], 0, 32'h20,  0);
        run_insn("R9 illegal opcode", 32'd20, mem[5], 1, 32'h0,   0);
        run_insn("R10 start held while busy", 32'd24, mem[6], 0, 32'h58, 1);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule